// File: doc/BRIEF.md
# Automatic UART Flow Control Engine

This block sits beside one UART channel and keeps the receive FIFO from overflowing by throttling the far-end transmitter. Two throttling methods are available and may be enabled together. In software mode it asks the local serializer to insert stop or resume control characters into the outgoing stream. In hardware mode it drives a handshake output low when the FIFO gets too full. It also works the other way round: received stop/resume characters, or a deasserted remote handshake input, hold back the local transmitter.

Two programmable thresholds provide hysteresis. Throttling begins when the receive FIFO count exceeds the high threshold and ends only once the count drops under the low threshold. The software stop/resume sequences are one or two characters long. A mapping input moves the handshake pair from the request/clear-to-send pins onto the terminal-ready/set-ready pins. The serializer tells the block when it takes an inserted character. It reads the hold output only when it is between characters, so a character already being shifted out is never cut short.

Top module: `flow_ctl_engine`

## Requirements
- R1: With `sw_tx_en_i` high and no stop already sent, `rx_count_i` strictly greater than `hi_thr_i` makes `ins_valid_o` rise on the next clock with `ins_char_o` equal to `xoff1_i` (`dual_i` low); a count equal to the threshold sends nothing.
- R2: A resume character (`xon1_i`) is inserted only after a stop was sent and once `rx_count_i` is strictly below `lo_thr_i`; while the count stays at or above `lo_thr_i`, no second stop is sent, and a low count with no stop outstanding sends nothing.
- R3: With `dual_i` high, stop inserts `xoff1_i` then `xoff2_i`, and resume inserts `xon1_i` then `xon2_i`, as two back-to-back insertions.
- R4: An insertion is handed over when `ins_valid_o` and `ins_ready_i` are both high at a clock edge. Until then `ins_valid_o` and `ins_char_o` stay unchanged. `data_hold_o` is high while an insertion is pending, so the insertion goes before the next data byte.
- R5: With `sw_rx_en_i` high, `rx_discard_o` is high in the same cycle as a valid received character equal to `xon1_i` or `xoff1_i`. With `dual_i` high, a match to `xon2_i` or `xoff2_i` also counts. Other characters, or any character with `sw_rx_en_i` low, leave it low.
- R6: A complete received stop sequence sets `data_hold_o` from the next cycle, and a complete resume sequence clears it. In single mode a complete sequence is `xoff1_i` or `xon1_i` alone. In dual mode it is the first character followed directly by the second, with no other valid character between them.
- R7: With `hw_en_i` high, the local handshake output goes low the cycle after `rx_count_i` exceeds `hi_thr_i`. It stays low while the count lies between the two thresholds and goes high again the cycle after the count falls below `lo_thr_i`. It is high after reset.
- R8: With `hw_en_i` low, `rts_o` follows `mcr_rts_i` and `dtr_o` follows `mcr_dtr_i`, whatever `rx_count_i` is.
- R9: With `pin_map_i` low, the handshake drives `rts_o` and is gated by `cts_i`. With it high, the handshake drives `dtr_o` and is gated by `dsr_i`, and the unmapped output follows its modem bit.
- R10: With `hw_en_i` high, a low remote input on the selected pin holds `data_hold_o` high in the same cycle, and the unselected pin has no effect. With `hw_en_i` low, both remote inputs have no effect.
- R11: Thresholds are 8-bit values and the full 1 to 128 range works; with `hi_thr_i` = 128 a count of 128 sends nothing and 129 sends a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_tx_en_i | input | 1 | Enable stop/resume character insertion |
| sw_rx_en_i | input | 1 | Enable detection of received control characters |
| dual_i | input | 1 | Two-character control sequences |
| hw_en_i | input | 1 | Enable automatic handshake pins |
| pin_map_i | input | 1 | Move handshake to the terminal-ready/set-ready pair |
| hi_thr_i | input | 8 | High receive threshold |
| lo_thr_i | input | 8 | Low receive threshold |
| xon1_i | input | 8 | First resume character |
| xon2_i | input | 8 | Second resume character |
| xoff1_i | input | 8 | First stop character |
| xoff2_i | input | 8 | Second stop character |
| rx_count_i | input | 8 | Receive FIFO fill count |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 8 | Received character |
| rx_discard_o | output | 1 | Received character is control, do not store |
| ins_ready_i | input | 1 | Serializer takes the inserted character |
| ins_valid_o | output | 1 | Control character insertion pending |
| ins_char_o | output | 8 | Character to insert |
| data_hold_o | output | 1 | Do not start the next data character |
| mcr_rts_i | input | 1 | Software request-to-send bit |
| mcr_dtr_i | input | 1 | Software terminal-ready bit |
| cts_i | input | 1 | Remote clear-to-send, high = go |
| dsr_i | input | 1 | Remote set-ready, high = go |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Terminal-ready output |

## Verification
The bench uses the default widths: an 8-bit count and 8-bit characters. With these, a 128 high threshold can be checked against counts of 128 and 129, and dual sequences built from distinct first and second bytes show that a second byte arriving alone, or after an intervening character, completes no sequence. Insertions are compared against a queue of expected characters, so a stop that is repeated or a resume that has no stop before it shows up as an unexpected transfer. Holding the serializer not ready exposes the stability and priority of a pending insertion.

// File: rtl/flow_ctl_pkg.sv
package flow_ctl_pkg;
  typedef enum logic {SEQ_XON = 1'b0, SEQ_XOFF = 1'b1} seq_kind_e;
endpackage

// File: rtl/fc_rx_detect.sv
module fc_rx_detect #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dual_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_char_i,
  input  logic [CHAR_W-1:0] xon1_i,
  input  logic [CHAR_W-1:0] xon2_i,
  input  logic [CHAR_W-1:0] xoff1_i,
  input  logic [CHAR_W-1:0] xoff2_i,
  output logic              discard_o,
  output logic              pause_o
);
  logic m_on1, m_on2, m_off1, m_off2;
  logic pend_on_q, pend_off_q, pause_q;
  logic hit, done_off, done_on;

  assign m_on1  = rx_char_i == xon1_i;
  assign m_on2  = rx_char_i == xon2_i;
  assign m_off1 = rx_char_i == xoff1_i;
  assign m_off2 = rx_char_i == xoff2_i;
  assign hit    = rx_valid_i && en_i;

  assign discard_o = hit && (m_on1 || m_off1 || (dual_i && (m_on2 || m_off2)));
  assign done_off  = hit && (dual_i ? (pend_off_q && m_off2) : m_off1);
  assign done_on   = hit && (dual_i ? (pend_on_q && m_on2) : m_on1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_on_q  <= 1'b0;
      pend_off_q <= 1'b0;
      pause_q    <= 1'b0;
    end else begin
      if (hit) begin
        // any valid character breaks a partial sequence
        pend_off_q <= dual_i && m_off1;
        pend_on_q  <= dual_i && m_on1;
      end
      if (!en_i)         pause_q <= 1'b0;
      else if (done_off) pause_q <= 1'b1;
      else if (done_on)  pause_q <= 1'b0;
    end
  end

  assign pause_o = pause_q;

  assert_single_xoff_pauses_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && en_i && !dual_i && rx_char_i == xoff1_i) |=> pause_o);
  assert_disabled_no_discard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !discard_o);
endmodule

// File: rtl/fc_tx_inserter.sv
module fc_tx_inserter
  import flow_ctl_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dual_i,
  input  logic              above_hi_i,
  input  logic              below_lo_i,
  input  logic [CHAR_W-1:0] xon1_i,
  input  logic [CHAR_W-1:0] xon2_i,
  input  logic [CHAR_W-1:0] xoff1_i,
  input  logic [CHAR_W-1:0] xoff2_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] char_o
);
  logic      active_q, idx_q, xoff_sent_q;
  seq_kind_e kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      idx_q       <= 1'b0;
      xoff_sent_q <= 1'b0;
      kind_q      <= SEQ_XON;
    end else if (!active_q) begin
      if (en_i && above_hi_i && !xoff_sent_q) begin
        active_q    <= 1'b1;
        idx_q       <= 1'b0;
        kind_q      <= SEQ_XOFF;
        xoff_sent_q <= 1'b1;
      end else if (en_i && below_lo_i && xoff_sent_q) begin
        active_q    <= 1'b1;
        idx_q       <= 1'b0;
        kind_q      <= SEQ_XON;
        xoff_sent_q <= 1'b0;
      end
    end else if (ready_i) begin
      if (dual_i && !idx_q) idx_q    <= 1'b1;
      else                  active_q <= 1'b0;
    end
  end

  always_comb begin
    if (kind_q == SEQ_XOFF) char_o = idx_q ? xoff2_i : xoff1_i;
    else                    char_o = idx_q ? xon2_i  : xon1_i;
  end
  assign valid_o = active_q;

  assert_xoff_starts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && above_hi_i && !xoff_sent_q && !active_q) |=> (valid_o && kind_q == SEQ_XOFF));
  assert_ins_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_q) && $stable(kind_q)));
endmodule

// File: rtl/fc_hw_handshake.sv
module fc_hw_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic above_hi_i,
  input  logic below_lo_i,
  input  logic pin_map_i,
  input  logic mcr_rts_i,
  input  logic mcr_dtr_i,
  input  logic cts_i,
  input  logic dsr_i,
  output logic rts_o,
  output logic dtr_o,
  output logic remote_block_o
);
  logic ready_q, hs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ready_q <= 1'b1;
    else if (!en_i)      ready_q <= 1'b1;
    else if (above_hi_i) ready_q <= 1'b0;
    else if (below_lo_i) ready_q <= 1'b1;
  end

  assign hs             = ready_q;
  assign rts_o          = (en_i && !pin_map_i) ? hs : mcr_rts_i;
  assign dtr_o          = (en_i &&  pin_map_i) ? hs : mcr_dtr_i;
  assign remote_block_o = en_i && !(pin_map_i ? dsr_i : cts_i);

  assert_hs_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && above_hi_i) |=> !ready_q);
  assert_hs_rises_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && below_lo_i && !above_hi_i) |=> ready_q);
endmodule

// File: rtl/flow_ctl_engine.sv
module flow_ctl_engine #(
  parameter int CNT_W  = 8,
  parameter int THR_W  = 8,
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_tx_en_i,
  input  logic              sw_rx_en_i,
  input  logic              dual_i,
  input  logic              hw_en_i,
  input  logic              pin_map_i,
  input  logic [THR_W-1:0]  hi_thr_i,
  input  logic [THR_W-1:0]  lo_thr_i,
  input  logic [CHAR_W-1:0] xon1_i,
  input  logic [CHAR_W-1:0] xon2_i,
  input  logic [CHAR_W-1:0] xoff1_i,
  input  logic [CHAR_W-1:0] xoff2_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_char_i,
  output logic              rx_discard_o,
  input  logic              ins_ready_i,
  output logic              ins_valid_o,
  output logic [CHAR_W-1:0] ins_char_o,
  output logic              data_hold_o,
  input  logic              mcr_rts_i,
  input  logic              mcr_dtr_i,
  input  logic              cts_i,
  input  logic              dsr_i,
  output logic              rts_o,
  output logic              dtr_o
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic above_hi, below_lo, sw_pause, remote_block;

  assign above_hi = CMP_W'(rx_count_i) > CMP_W'(hi_thr_i);
  assign below_lo = CMP_W'(rx_count_i) < CMP_W'(lo_thr_i);

  fc_rx_detect #(.CHAR_W(CHAR_W)) u_rx_detect (
    .clk_i, .rst_ni, .en_i(sw_rx_en_i), .dual_i, .rx_valid_i, .rx_char_i,
    .xon1_i, .xon2_i, .xoff1_i, .xoff2_i,
    .discard_o(rx_discard_o), .pause_o(sw_pause)
  );

  fc_tx_inserter #(.CHAR_W(CHAR_W)) u_tx_inserter (
    .clk_i, .rst_ni, .en_i(sw_tx_en_i), .dual_i,
    .above_hi_i(above_hi), .below_lo_i(below_lo),
    .xon1_i, .xon2_i, .xoff1_i, .xoff2_i,
    .ready_i(ins_ready_i), .valid_o(ins_valid_o), .char_o(ins_char_o)
  );

  fc_hw_handshake u_hw_handshake (
    .clk_i, .rst_ni, .en_i(hw_en_i), .above_hi_i(above_hi), .below_lo_i(below_lo),
    .pin_map_i, .mcr_rts_i, .mcr_dtr_i, .cts_i, .dsr_i,
    .rts_o, .dtr_o, .remote_block_o(remote_block)
  );

  // pending insertion outranks the next data byte
  assign data_hold_o = sw_pause || remote_block || ins_valid_o;

  assert_map_rts_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_map_i |-> (rts_o == mcr_rts_i));
  assert_hw_off_dtr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_en_i |-> (dtr_o == mcr_dtr_i && rts_o == mcr_rts_i));
  assert_cts_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_en_i && !pin_map_i && !cts_i) |-> data_hold_o);
  assert_pending_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o |-> data_hold_o);
endmodule

// File: tb/flow_ctl_engine_bench.sv
module flow_ctl_engine_bench;
  localparam time CLK = 5ns;

  logic clk = 0, rst_n = 0;
  logic sw_tx_en = 0, sw_rx_en = 0, dual = 0, hw_en = 1, pin_map = 0;
  logic [7:0] hi_thr = 8'd10, lo_thr = 8'd4;
  logic [7:0] xon1 = 8'h11, xon2 = 8'h91, xoff1 = 8'h13, xoff2 = 8'h93;
  logic [7:0] rx_count = 0, rx_char = 0;
  logic rx_valid = 0, ins_ready = 1;
  logic mcr_rts = 0, mcr_dtr = 1, cts = 1, dsr = 1;
  logic rx_discard, ins_valid, data_hold, rts, dtr;
  logic [7:0] ins_char;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #(CLK/2) clk = ~clk;

  flow_ctl_engine u_flow_ctl_engine (
    .clk_i(clk), .rst_ni(rst_n), .sw_tx_en_i(sw_tx_en), .sw_rx_en_i(sw_rx_en),
    .dual_i(dual), .hw_en_i(hw_en), .pin_map_i(pin_map),
    .hi_thr_i(hi_thr), .lo_thr_i(lo_thr),
    .xon1_i(xon1), .xon2_i(xon2), .xoff1_i(xoff1), .xoff2_i(xoff2),
    .rx_count_i(rx_count), .rx_valid_i(rx_valid), .rx_char_i(rx_char),
    .rx_discard_o(rx_discard), .ins_ready_i(ins_ready), .ins_valid_o(ins_valid),
    .ins_char_o(ins_char), .data_hold_o(data_hold),
    .mcr_rts_i(mcr_rts), .mcr_dtr_i(mcr_dtr), .cts_i(cts), .dsr_i(dsr),
    .rts_o(rts), .dtr_o(dtr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: a transfer happens at the posedge after a valid&&ready sample
  always @(negedge clk) begin
    #1;
    if (rst_n && ins_valid && ins_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2 unexpected insertion actual=%0h expected=none", ins_char);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R1/R3 inserted char", ins_char, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_count(input logic [7:0] v);
    @(negedge clk);
    rx_count = v;
    idle(5);
  endtask

  task automatic drained(input string tag);
    chk(tag, exp_q.size(), 0);
  endtask

  task automatic rx_send(input logic [7:0] c, input logic exp_disc, input logic exp_hold,
                         input string tag);
    @(negedge clk);
    rx_valid = 1; rx_char = c;
    #1 chk({tag, " discard"}, rx_discard, exp_disc);
    @(negedge clk);
    rx_valid = 0;
    #1 chk({tag, " hold"}, data_hold, exp_hold);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R4 reset ins_valid", ins_valid, 0);
    chk("R6 reset hold", data_hold, 0);
    chk("R7 reset handshake high", rts, 1);

    // software insertion, single mode
    hw_en = 0; sw_tx_en = 1;
    set_count(10);
    drained("R1 equal to threshold sends nothing");
    exp_q.push_back(xoff1);
    set_count(11);
    drained("R1 xoff sent");
    set_count(7);
    set_count(12);
    drained("R2 no repeated xoff");
    exp_q.push_back(xon1);
    set_count(3);
    drained("R2 xon sent");
    set_count(2);
    drained("R2 no xon without xoff");

    // dual mode
    dual = 1;
    exp_q.push_back(xoff1); exp_q.push_back(xoff2);
    set_count(11);
    drained("R3 dual xoff pair");
    exp_q.push_back(xon1); exp_q.push_back(xon2);
    set_count(3);
    drained("R3 dual xon pair");

    // stalled serializer
    dual = 0;
    @(negedge clk); ins_ready = 0; rx_count = 11;
    idle(3); #1;
    chk("R4 pending valid", ins_valid, 1);
    chk("R4 pending char", ins_char, xoff1);
    chk("R4 pending holds data", data_hold, 1);
    idle(2); #1;
    chk("R4 still stable", ins_char, xoff1);
    exp_q.push_back(xoff1);
    @(negedge clk); ins_ready = 1;
    idle(3);
    drained("R4 released");
    #1 chk("R4 hold released", data_hold, 0);
    exp_q.push_back(xon1);
    set_count(3);
    drained("R4 xon after stall");

    // 128 threshold
    hi_thr = 8'd128; lo_thr = 8'd100;
    set_count(128);
    drained("R11 count 128 no xoff");
    exp_q.push_back(xoff1);
    set_count(129);
    drained("R11 count 129 xoff");
    set_count(100);
    drained("R11 count at low no xon");
    exp_q.push_back(xon1);
    set_count(99);
    drained("R11 count 99 xon");
    sw_tx_en = 0;
    set_count(0);

    // receive detection, single mode
    sw_rx_en = 1;
    rx_send(8'h41, 0, 0, "R5 data char");
    rx_send(xoff1, 1, 1, "R6 single xoff");
    rx_send(8'h41, 0, 1, "R6 data while paused");
    rx_send(xoff2, 0, 1, "R5 second char ignored in single");
    rx_send(xon1, 1, 0, "R6 single xon");

    // receive detection, dual mode
    dual = 1;
    rx_send(xoff1, 1, 0, "R6 dual first only");
    rx_send(8'h41, 0, 0, "R6 dual broken");
    rx_send(xoff2, 1, 0, "R6 dual second alone");
    rx_send(xoff1, 1, 0, "R6 dual first");
    rx_send(xoff2, 1, 1, "R6 dual complete xoff");
    rx_send(xon1, 1, 1, "R6 dual xon first");
    rx_send(xon2, 1, 0, "R6 dual complete xon");
    sw_rx_en = 0;
    rx_send(xoff1, 0, 0, "R5 detect disabled");
    dual = 0;

    // hardware handshake
    hi_thr = 8'd10; lo_thr = 8'd4;
    hw_en = 1; mcr_rts = 0; mcr_dtr = 1;
    @(negedge clk); #1;
    chk("R7 enabled high", rts, 1);
    set_count(11); #1;
    chk("R7 drops above high", rts, 0);
    set_count(5); #1;
    chk("R7 holds between", rts, 0);
    set_count(3); #1;
    chk("R7 rises below low", rts, 1);
    pin_map = 1; mcr_dtr = 0;
    set_count(11); #1;
    chk("R9 mapped dtr drops", dtr, 0);
    chk("R9 unmapped rts follows bit", rts, 0);
    set_count(3); #1;
    chk("R9 mapped dtr rises", dtr, 1);
    pin_map = 0;

    hw_en = 0; mcr_rts = 1; mcr_dtr = 0;
    set_count(11); #1;
    chk("R8 rts follows bit", rts, 1);
    chk("R8 dtr follows bit", dtr, 0);
    set_count(0);

    hw_en = 1; cts = 0;
    @(negedge clk); #1;
    chk("R10 cts low holds", data_hold, 1);
    cts = 1; dsr = 0;
    @(negedge clk); #1;
    chk("R10 dsr ignored unmapped", data_hold, 0);
    pin_map = 1;
    @(negedge clk); #1;
    chk("R10 dsr holds mapped", data_hold, 1);
    hw_en = 0; cts = 0;
    @(negedge clk); #1;
    chk("R10 hw off ignores inputs", data_hold, 0);

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule